// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is an 18-bit first-in first-out buffer. The producer writes on one clock and the consumer reads on another, unrelated clock. Every control input and every status output is active low. Besides empty and full, the buffer reports three more conditions. Half-full is asserted when more than half of the storage holds data. Almost-empty and almost-full are each set by a threshold held in an offset register. The depth is a parameter that must be a power of two, from 64 to 4096 words.

When the load control is held low, the ordinary data path is redirected to the two offset registers. Enabled write-clock edges store the low bits of the input bus into the almost-empty register and then into the almost-full register, in turn. Enabled read-clock edges present those registers on the output bus in the same alternating order, using a separate selector. A retransmit strobe on the read side returns the read position to the first word written since reset, so a short message can be replayed.

The write and read positions cross between the clock domains as Gray code through two-stage synchronizers. Each flag is registered in the domain that uses it.

Top module: `prog_flag_fifo`

## Requirements
- R1: On a rising wrClk edge with wrEnN=0, loadN=1 and fullN=1, the 18-bit dIn word is stored. Words leave in the same order they were stored.
- R2: A write attempted while fullN=0 is ignored. No stored word is overwritten, and the word count does not exceed DEPTH.
- R3: On a rising rdClk edge with rdEnN=0, loadN=1, retransmitN=1 and emptyN=1, the oldest word is placed on qOut after that edge. At all other times qOut holds its value.
- R4: A read attempted while emptyN=0 is ignored. qOut keeps its value and the read position does not move.
- R5: emptyN is low in the read domain when the stored count is zero. fullN is low in the write domain when the stored count equals DEPTH.
- R6: halfFullN is low, in the write domain, while the stored count is greater than DEPTH/2.
- R7: almostEmptyN is low, in the read domain, while the stored count is less than or equal to the almost-empty offset.
- R8: almostFullN is low, in the write domain, while DEPTH minus the stored count is less than or equal to the almost-full offset.
- R9: With loadN=0, each write-clock edge with wrEnN=0 stores dIn[CW-1:0], where CW=log2(DEPTH)+1. The first such edge stores into the almost-empty offset, the second into the almost-full offset, and the order then repeats. The FIFO memory and its counts are left untouched.
- R10: With loadN=0, each read-clock edge with rdEnN=0 puts an offset, zero-extended to 18 bits, on qOut. The order is almost-empty first, then almost-full, then repeating, with its own selector. The FIFO read position does not move.
- R11: Reset (rstN=0, asynchronous) empties the FIFO, sets qOut to 0, sets both offsets to 7, and points both load selectors at the almost-empty offset.
- R12: retransmitN=0 at a rising rdClk edge sets the read position back to the first word written since reset. This takes priority over a read on the same edge. Replay is valid while no more than DEPTH words have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEnN | input | 1 | Active-low write enable |
| rdEnN | input | 1 | Active-low read enable |
| loadN | input | 1 | Active-low redirect of the data path to the offset registers |
| retransmitN | input | 1 | Active-low rewind of the read position |
| dIn | input | 18 | Write data |
| qOut | output | 18 | Read data or offset read-back |
| emptyN | output | 1 | Low when empty (read domain) |
| fullN | output | 1 | Low when full (write domain) |
| halfFullN | output | 1 | Low when more than half full (write domain) |
| almostEmptyN | output | 1 | Low at or below the almost-empty offset (read domain) |
| almostFullN | output | 1 | Low when free space is at or below the almost-full offset (write domain) |

## Verification
The bench probes the exact threshold counts: 7 and 8 words for almost-empty, 32 and 33 for half-full, and 56 and 57 for almost-full. A comparison that is off by one, or that uses strict instead of inclusive, moves the flag by one word and is caught. It writes past full and reads past empty. An overflowing design would lose or duplicate words in the drained sequence, and an underflowing design would change qOut or return a stale word after the next write. Offset loading and read-back are checked for their alternating order and for leaving the memory alone; swapped selectors or a read pointer that moves during read-back return the wrong values. Retransmit after a partial drain must replay from the first word, not from the current position.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  localparam int DATA_W = 18;

  // strobes passed from control to datapath
  typedef struct packed {
    logic memWrite;
    logic offWrite;
    logic memRead;
    logic offRead;
  } strobe_t;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          loadN,
  input  logic          retransmitN,
  input  logic [CW-1:0] aeOffset,
  input  logic [CW-1:0] afOffset,
  output strobe_t       strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          fullN,
  output logic          halfFullN,
  output logic          almostEmptyN,
  output logic          almostFullN
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

  function automatic logic [CW-1:0] bin2gray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] gray2bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [CW-1:0] wrBin, wrBinNext, wrGray, rdGraySync, rdBinSync, wrCount, freeSlots;
  logic doWrite;

  fifo_gray_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .dIn(rdGray), .dOut(rdGraySync)
  );

  always_comb begin
    rdBinSync = gray2bin(rdGraySync);
    wrCount   = wrBin - rdBinSync;
    freeSlots = DEPTH_C - wrCount;
    fullN     = (wrCount != DEPTH_C);
    doWrite   = !wrEnN && loadN && fullN;
    wrBinNext = wrBin + {{(CW-1){1'b0}}, doWrite};
    halfFullN   = !(wrCount > HALF_C);
    almostFullN = !(freeSlots <= afOffset);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= bin2gray(wrBinNext);
    end
  end

  // ---------------- read domain ----------------
  logic [CW-1:0] rdBin, rdBinNext, rdGray, wrGraySync, wrBinSync, rdCount;
  logic doRead;

  fifo_gray_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .dIn(wrGray), .dOut(wrGraySync)
  );

  always_comb begin
    wrBinSync    = gray2bin(wrGraySync);
    rdCount      = wrBinSync - rdBin;
    emptyN       = (rdCount != '0);
    doRead       = !rdEnN && loadN && retransmitN && emptyN;
    almostEmptyN = !(rdCount <= aeOffset);
    if (!retransmitN) rdBinNext = '0;
    else              rdBinNext = rdBin + {{(CW-1){1'b0}}, doRead};
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= bin2gray(rdBinNext);
    end
  end

  // ---------------- strobes to datapath ----------------
  always_comb begin
    strobes.memWrite = doWrite;
    strobes.offWrite = !wrEnN && !loadN;
    strobes.memRead  = doRead;
    strobes.offRead  = !rdEnN && !loadN;
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];

  // ---------------- assertions ----------------
  assert_no_overflow_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    wrCount <= DEPTH_C);

  assert_full_blocks_write_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fullN && !wrEnN) |=> $stable(wrBin));

  assert_empty_blocks_read_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    (!emptyN && retransmitN) |=> $stable(rdBin));

  assert_retransmit_rewinds_R12: assert property (@(posedge rdClk) disable iff (!rstN)
    !retransmitN |=> (rdBin == '0));

  assert_gray_single_step_R1: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  assert_load_keeps_pointer_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    !loadN |=> $stable(wrBin));
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DEFAULT_OFFSET = 7,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qOut,
  output logic [CW-1:0]     aeOffset,
  output logic [CW-1:0]     afOffset
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic wrSel;  // 0 selects almost-empty offset
  logic rdSel;

  always_ff @(posedge wrClk) begin
    if (strobes.memWrite) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOffset <= CW'(DEFAULT_OFFSET);
      afOffset <= CW'(DEFAULT_OFFSET);
      wrSel    <= 1'b0;
    end else if (strobes.offWrite) begin
      if (wrSel) afOffset <= dIn[CW-1:0];
      else       aeOffset <= dIn[CW-1:0];
      wrSel <= !wrSel;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      qOut  <= '0;
      rdSel <= 1'b0;
    end else if (strobes.offRead) begin
      qOut  <= {{(DATA_W-CW){1'b0}}, (rdSel ? afOffset : aeOffset)};
      rdSel <= !rdSel;
    end else if (strobes.memRead) begin
      qOut <= mem[rdAddr];
    end
  end

  assert_load_alternates_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    strobes.offWrite |=> (wrSel != $past(wrSel)));

  assert_readback_alternates_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    strobes.offRead |=> (rdSel != $past(rdSel)));

  assert_write_exclusive_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0({strobes.memWrite, strobes.offWrite}));
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SYNC_STAGES = 2,
  parameter int DEFAULT_OFFSET = 7
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        wrEnN,
  input  logic        rdEnN,
  input  logic        loadN,
  input  logic        retransmitN,
  input  logic [17:0] dIn,
  output logic [17:0] qOut,
  output logic        emptyN,
  output logic        fullN,
  output logic        halfFullN,
  output logic        almostEmptyN,
  output logic        almostFullN
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  strobe_t       strobes;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [CW-1:0] aeOffset, afOffset;

  fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN), .retransmitN(retransmitN),
    .aeOffset(aeOffset), .afOffset(afOffset),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .halfFullN(halfFullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  fifo_datapath #(.DEPTH(DEPTH), .DEFAULT_OFFSET(DEFAULT_OFFSET)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dIn(dIn), .qOut(qOut), .aeOffset(aeOffset), .afOffset(afOffset)
  );
endmodule

// File: tb/prog_flag_fifo_tb.sv
module prog_flag_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 3 / 2;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEnN = 1, rdEnN = 1, loadN = 1, retransmitN = 1;
  logic [17:0] dIn = '0;
  logic [17:0] qOut;
  logic emptyN, fullN, halfFullN, almostEmptyN, almostFullN;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) wrClk = ~wrClk;
  always #(RD_PERIOD / 2.0) rdClk = ~rdClk;

  prog_flag_fifo u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN), .retransmitN(retransmitN),
    .dIn(dIn), .qOut(qOut), .emptyN(emptyN), .fullN(fullN),
    .halfFullN(halfFullN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    wrEnN = 1; rdEnN = 1; loadN = 1; retransmitN = 1; dIn = '0;
    rstN = 0;
    repeat (3) @(negedge rdClk);
    @(negedge wrClk);
    rstN = 1;
    repeat (3) @(negedge rdClk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  task automatic push(input logic [17:0] d);
    @(negedge wrClk);
    dIn = d; wrEnN = 0;
    @(negedge wrClk);
    wrEnN = 1;
  endtask

  task automatic pop(output logic [17:0] d);
    @(negedge rdClk);
    rdEnN = 0;
    @(negedge rdClk);
    rdEnN = 1;
    d = qOut;
  endtask

  task automatic testReset();
    doReset();
    check("R11 qOut", qOut, 0);
    check("R11 emptyN", emptyN, 0);
    check("R11 fullN", fullN, 1);
    check("R11 halfFullN", halfFullN, 1);
    check("R11 almostEmptyN", almostEmptyN, 0);
    check("R11 almostFullN", almostFullN, 1);
    loadN = 0;
    begin
      logic [17:0] v;
      pop(v); check("R11 default ae offset", v, 7);
      pop(v); check("R11 default af offset", v, 7);
    end
    loadN = 1;
  endtask

  task automatic testOrder();
    logic [17:0] v;
    doReset();
    for (int i = 0; i < 5; i++) push(18'h2A000 + 18'(i * 3));
    settle();
    check("R5 emptyN after writes", emptyN, 1);
    check("R7 almostEmptyN at 5", almostEmptyN, 0);
    for (int i = 0; i < 5; i++) begin
      pop(v);
      check("R1 R3 order", v, 18'h2A000 + 18'(i * 3));
    end
    check("R5 emptyN after drain", emptyN, 0);
    @(negedge rdClk);
    check("R3 qOut held while idle", qOut, 18'h2A000 + 18'd12);
  endtask

  task automatic testLevels();
    logic [17:0] v;
    int mism;
    doReset();
    for (int i = 0; i < 7; i++) push(18'(i));
    settle();
    check("R7 almostEmptyN at 7", almostEmptyN, 0);
    push(18'd7);
    settle();
    check("R7 almostEmptyN at 8", almostEmptyN, 1);
    for (int i = 8; i < 32; i++) push(18'(i));
    check("R6 halfFullN at 32", halfFullN, 1);
    push(18'd32);
    check("R6 halfFullN at 33", halfFullN, 0);
    for (int i = 33; i < 56; i++) push(18'(i));
    check("R8 almostFullN at 56", almostFullN, 1);
    push(18'd56);
    check("R8 almostFullN at 57", almostFullN, 0);
    for (int i = 57; i < 64; i++) push(18'(i));
    check("R5 fullN at 64", fullN, 0);
    push(18'h3FFFF);
    push(18'h3FFFE);
    check("R2 fullN stays low", fullN, 0);
    settle();
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      pop(v);
      if (v !== 18'(i)) mism++;
    end
    check("R2 drained sequence intact", mism, 0);
    check("R4 emptyN after drain", emptyN, 0);
    pop(v);
    check("R4 qOut unchanged on empty read", v, 18'd63);
    push(18'h155);
    settle();
    pop(v);
    check("R4 read pointer did not move", v, 18'h155);
  endtask

  task automatic testOffsets();
    logic [17:0] v;
    doReset();
    loadN = 0;
    push(18'd3);
    push(18'd10);
    pop(v); check("R10 readback ae", v, 3);
    pop(v); check("R10 readback af", v, 10);
    pop(v); check("R10 readback wraps", v, 3);
    loadN = 1;
    settle();
    check("R9 memory untouched by load", emptyN, 0);
    for (int i = 0; i < 4; i++) push(18'h100 + 18'(i));
    settle();
    check("R7 almostEmptyN at 4 with offset 3", almostEmptyN, 1);
    pop(v);
    check("R10 first word after readback", v, 18'h100);
    @(negedge rdClk);
    check("R7 almostEmptyN at 3 with offset 3", almostEmptyN, 0);
    for (int i = 0; i < 50; i++) push(18'h200 + 18'(i));
    check("R8 almostFullN at 53 with offset 10", almostFullN, 1);
    push(18'h300);
    check("R8 almostFullN at 54 with offset 10", almostFullN, 0);
  endtask

  task automatic testRetransmit();
    logic [17:0] v;
    doReset();
    for (int i = 0; i < 4; i++) push(18'h10 + 18'(i));
    settle();
    pop(v); pop(v);
    check("R3 partial read", v, 18'h11);
    @(negedge rdClk);
    retransmitN = 0; rdEnN = 0;
    @(negedge rdClk);
    retransmitN = 1; rdEnN = 1;
    check("R12 retransmit beats read", qOut, 18'h11);
    for (int i = 0; i < 4; i++) begin
      pop(v);
      check("R12 replay from first word", v, 18'h10 + 18'(i));
    end
  endtask

  initial begin
    testReset();
    testOrder();
    testLevels();
    testOffsets();
    testRetransmit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule